// File: doc/BRIEF.md
# Four-Cache MSI Snooping Coherence Controller

The block keeps the tag state of several private caches that share one geometry, and it holds them coherent over a single snooping bus with the three-state MSI protocol. Each core offers a block-aligned access, a load or a store, as a valid bit and an address. The bus serves one access per cycle. In that cycle the requesting cache looks the address up and updates its line state and LRU order. Every other cache snoops the same address and reacts: it invalidates its copy on a store, and it downgrades a Modified copy to Shared on a load.

Only tags, line states and event counters are kept. No data is stored and memory latency is not modelled. For each cache the block counts hits, misses, evictions and invalidations forced by coherence, and these counts are the main observable result. The low `SET_BITS` bits of an address pick the set and the rest form the tag.

Top module: `msi_snoop_coherence`

## Requirements
- R1: After reset every counter reads zero and every line is Invalid, so the first access of any cache to any block is a miss.
- R2: At most one access is granted per cycle, and only to a core with its valid bit set. The grant goes to the first valid core after the last granted one in ascending circular order. Core 0 is first after reset, and cores without a valid access are skipped.
- R3: An access is a hit when its set holds a non-Invalid line with a matching tag, and the requester's hit counter increments by one. Otherwise its miss counter increments by one.
- R4: A miss fills the lowest-numbered Invalid way of the set when one exists. If none exists, it replaces the least recently used way, and only then the eviction counter increments.
- R5: Every granted access, hit or fill, makes its line the most recently used in its set. Snoops leave the LRU order untouched.
- R6: A granted store moves every other cache's copy of the block to Invalid, and each such cache's invalidation counter increments by one.
- R7: A granted load downgrades a Modified copy in another cache to Shared. A load miss fills Shared and a store fills or upgrades to Modified, so a later store by the downgraded cache invalidates the reader's copy.
- R8: A store hit on a Modified line counts only as a hit and changes no counter of any other cache.
- R9: An access to a line that coherence invalidated is a miss that refills the line in place, without counting an eviction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | NUM_CORES | Per-core access present |
| acc_store_i | input | NUM_CORES | Per-core access is a store (1) or load (0) |
| acc_addr_i | input | NUM_CORES*ADDR_W | Per-core block address, core c at bits [c*ADDR_W +: ADDR_W] |
| grant_o | output | NUM_CORES | One-hot: access of this core is applied at the coming edge |
| hit_cnt_o | output | NUM_CORES*CNT_W | Per-cache hit count |
| miss_cnt_o | output | NUM_CORES*CNT_W | Per-cache miss count |
| evict_cnt_o | output | NUM_CORES*CNT_W | Per-cache replacement eviction count |
| inval_cnt_o | output | NUM_CORES*CNT_W | Per-cache coherence invalidation count |

## Verification
On every cycle the assertions check that the grant is one-hot and confined to valid cores. They also check that each granted access moves exactly one of hit or miss, that hits never evict, and that snooping caches never count lookups, or invalidations on loads. The order of LRU victims, the downgrade and invalidation chains between caches, and the round-robin skipping of cores whose streams have ended only show up through the bench's scenarios. These are a reference model fed with directed coherence sequences and random multi-core streams of unequal length.

// File: rtl/msi_cc_pkg.sv
package msi_cc_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_MOD = 2'd2
  } line_state_e;
endpackage

// File: rtl/msi_rr_arbiter.sv
module msi_rr_arbiter #(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CORES-1:0] valid_i,
  output logic [NUM_CORES-1:0] grant_o
);
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic [IDX_W-1:0] last_q;
  logic [IDX_W-1:0] next_idx;
  logic             found;

  always_comb begin
    grant_o  = '0;
    found    = 1'b0;
    next_idx = last_q;
    for (int off = 1; off <= NUM_CORES; off++) begin
      int idx;
      idx = (int'(last_q) + off) % NUM_CORES;
      if (!found && valid_i[idx]) begin
        found         = 1'b1;
        grant_o[idx]  = 1'b1;
        next_idx      = IDX_W'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= IDX_W'(NUM_CORES - 1);
    else if (found) last_q <= next_idx;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R2
  AST_GRANT_IN_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~valid_i) == '0); // R2
  AST_GRANT_WHEN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|valid_i) |-> (|grant_o)); // R2
endmodule

// File: rtl/msi_cache_bank.sv
module msi_cache_bank
  import msi_cc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SET_BITS = 2,
  parameter int WAYS     = 2,
  parameter int CNT_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              snoop_i,
  input  logic              store_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o,
  output logic [CNT_W-1:0]  evict_cnt_o,
  output logic [CNT_W-1:0]  inval_cnt_o
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int TAG_W = ADDR_W - SET_BITS;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  line_state_e      st_q  [SETS][WAYS];
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  logic [CNT_W-1:0] hit_cnt_q, miss_cnt_q, evict_cnt_q, inval_cnt_q;

  logic [SET_BITS-1:0] set_idx;
  logic [TAG_W-1:0]    tag;
  logic                hit, has_inv;
  logic [WAY_W-1:0]    hit_way, inv_way, lru_way, tgt_way;

  assign set_idx = addr_i[SET_BITS-1:0];
  assign tag     = addr_i[ADDR_W-1:SET_BITS];

  always_comb begin
    hit     = 1'b0;
    has_inv = 1'b0;
    hit_way = '0;
    inv_way = '0;
    lru_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (st_q[set_idx][w] != LS_INV && tag_q[set_idx][w] == tag) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (age_q[set_idx][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (st_q[set_idx][w] == LS_INV) begin
        has_inv = 1'b1;
        inv_way = WAY_W'(w);
      end
    end
    tgt_way = hit ? hit_way : (has_inv ? inv_way : lru_way);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          st_q[s][w]  <= LS_INV;
          age_q[s][w] <= WAY_W'(w);
        end
      end
      hit_cnt_q   <= '0;
      miss_cnt_q  <= '0;
      evict_cnt_q <= '0;
      inval_cnt_q <= '0;
    end else if (req_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == tgt_way) age_q[set_idx][w] <= '0;
        else if (age_q[set_idx][w] < age_q[set_idx][tgt_way])
          age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
      end
      if (hit) begin
        hit_cnt_q <= hit_cnt_q + 1'b1;
        if (store_i) st_q[set_idx][tgt_way] <= LS_MOD;
      end else begin
        miss_cnt_q             <= miss_cnt_q + 1'b1;
        tag_q[set_idx][tgt_way] <= tag;
        st_q[set_idx][tgt_way]  <= store_i ? LS_MOD : LS_SHR;
        if (!has_inv) evict_cnt_q <= evict_cnt_q + 1'b1;
      end
    end else if (snoop_i && hit) begin
      // a store always broadcasts; a Modified requester has no sharers to hit
      if (store_i) begin
        st_q[set_idx][hit_way] <= LS_INV;
        inval_cnt_q            <= inval_cnt_q + 1'b1;
      end else if (st_q[set_idx][hit_way] == LS_MOD) begin
        st_q[set_idx][hit_way] <= LS_SHR;
      end
    end
  end

  assign hit_cnt_o   = hit_cnt_q;
  assign miss_cnt_o  = miss_cnt_q;
  assign evict_cnt_o = evict_cnt_q;
  assign inval_cnt_o = inval_cnt_q;

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ((hit_cnt_q - $past(hit_cnt_q)) + (miss_cnt_q - $past(miss_cnt_q))) == CNT_W'(1)); // R3
  AST_HIT_NO_EVICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && hit) |=> $stable(evict_cnt_q)); // R4
  AST_SNOOP_NO_LOOKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_i |=> ($stable(hit_cnt_q) && $stable(miss_cnt_q))); // R6
  AST_LOAD_SNOOP_NO_INVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_i && !store_i) |=> $stable(inval_cnt_q)); // R7
  AST_REQ_SNOOP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && snoop_i)); // R2
endmodule

// File: rtl/msi_snoop_coherence.sv
module msi_snoop_coherence #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int SET_BITS  = 2,
  parameter int WAYS      = 2,
  parameter int CNT_W     = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CORES-1:0]       acc_valid_i,
  input  logic [NUM_CORES-1:0]       acc_store_i,
  input  logic [NUM_CORES*ADDR_W-1:0] acc_addr_i,
  output logic [NUM_CORES-1:0]       grant_o,
  output logic [NUM_CORES*CNT_W-1:0] hit_cnt_o,
  output logic [NUM_CORES*CNT_W-1:0] miss_cnt_o,
  output logic [NUM_CORES*CNT_W-1:0] evict_cnt_o,
  output logic [NUM_CORES*CNT_W-1:0] inval_cnt_o
);
  logic              bus_fire;
  logic              bus_store;
  logic [ADDR_W-1:0] bus_addr;

  msi_rr_arbiter #(.NUM_CORES(NUM_CORES)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (acc_valid_i),
    .grant_o (grant_o)
  );

  always_comb begin
    bus_store = 1'b0;
    bus_addr  = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (grant_o[c]) begin
        bus_store = acc_store_i[c];
        bus_addr  = acc_addr_i[c*ADDR_W +: ADDR_W];
      end
    end
  end

  assign bus_fire = |grant_o;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_bank
    msi_cache_bank #(
      .ADDR_W   (ADDR_W),
      .SET_BITS (SET_BITS),
      .WAYS     (WAYS),
      .CNT_W    (CNT_W)
    ) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (grant_o[c]),
      .snoop_i     (bus_fire && !grant_o[c]),
      .store_i     (bus_store),
      .addr_i      (bus_addr),
      .hit_cnt_o   (hit_cnt_o[c*CNT_W +: CNT_W]),
      .miss_cnt_o  (miss_cnt_o[c*CNT_W +: CNT_W]),
      .evict_cnt_o (evict_cnt_o[c*CNT_W +: CNT_W]),
      .inval_cnt_o (inval_cnt_o[c*CNT_W +: CNT_W])
    );
  end
endmodule

// File: tb/msi_snoop_coherence_tb.sv
module msi_snoop_coherence_tb;
  localparam int NC = 4, AW = 8, SB = 2, WY = 2, CW = 16;
  localparam int SETS = 1 << SB;
  localparam int SLOTS = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0] valid, store;
  logic [NC*AW-1:0] addr;
  logic [NC-1:0] grant;
  logic [NC*CW-1:0] hit_c, miss_c, evict_c, inval_c;

  always #5 clk = ~clk;

  msi_snoop_coherence #(.NUM_CORES(NC), .ADDR_W(AW), .SET_BITS(SB), .WAYS(WY), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_store_i(store), .acc_addr_i(addr),
    .grant_o(grant), .hit_cnt_o(hit_c), .miss_cnt_o(miss_c), .evict_cnt_o(evict_c), .inval_cnt_o(inval_c)
  );

  int n_chk = 0, n_fail = 0;
  // reference model: state 0 Invalid, 1 Shared, 2 Modified
  int m_tag [NC][SETS][WY];
  int m_st  [NC][SETS][WY];
  int m_age [NC][SETS][WY];
  int e_hit[NC], e_miss[NC], e_evict[NC], e_inval[NC];
  int rr_last;
  int s_addr [NC][SLOTS];
  bit s_st   [NC][SLOTS];
  int s_len[NC], s_pos[NC];

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int c = 0; c < NC; c++) begin
      e_hit[c] = 0; e_miss[c] = 0; e_evict[c] = 0; e_inval[c] = 0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WY; w++) begin
          m_tag[c][s][w] = 0; m_st[c][s][w] = 0; m_age[c][s][w] = w;
        end
    end
    rr_last = NC - 1;
  endfunction

  function automatic int find(int c, int s, int t);
    for (int w = 0; w < WY; w++)
      if (m_st[c][s][w] != 0 && m_tag[c][s][w] == t) return w;
    return -1;
  endfunction

  function automatic void model_access(int c, bit st, int a);
    int s, t, tw, old;
    s = a % SETS; t = a / SETS;
    tw = find(c, s, t);
    if (tw >= 0) begin
      e_hit[c]++;
      if (st) m_st[c][s][tw] = 2;
    end else begin
      e_miss[c]++;
      for (int w = WY - 1; w >= 0; w--) if (m_st[c][s][w] == 0) tw = w;
      if (tw < 0) begin
        for (int w = 0; w < WY; w++) if (m_age[c][s][w] == WY - 1) tw = w;
        e_evict[c]++;
      end
      m_tag[c][s][tw] = t;
      m_st[c][s][tw] = st ? 2 : 1;
    end
    old = m_age[c][s][tw];
    for (int w = 0; w < WY; w++)
      if (w == tw) m_age[c][s][w] = 0;
      else if (m_age[c][s][w] < old) m_age[c][s][w]++;
    for (int o = 0; o < NC; o++) begin
      int ow;
      if (o == c) continue;
      ow = find(o, s, t);
      if (ow < 0) continue;
      if (st) begin m_st[o][s][ow] = 0; e_inval[o]++; end
      else if (m_st[o][s][ow] == 2) m_st[o][s][ow] = 1;
    end
  endfunction

  function automatic int pick(logic [NC-1:0] v);
    for (int off = 1; off <= NC; off++) begin
      int i;
      i = (rr_last + off) % NC;
      if (v[i]) return i;
    end
    return -1;
  endfunction

  task automatic cmp_all();
    for (int c = 0; c < NC; c++) begin
      chk(int'(hit_c[c*CW +: CW]) == e_hit[c], "R3 hits", int'(hit_c[c*CW +: CW]), e_hit[c]);
      chk(int'(miss_c[c*CW +: CW]) == e_miss[c], "R3 misses", int'(miss_c[c*CW +: CW]), e_miss[c]);
      chk(int'(evict_c[c*CW +: CW]) == e_evict[c], "R4 evictions", int'(evict_c[c*CW +: CW]), e_evict[c]);
      chk(int'(inval_c[c*CW +: CW]) == e_inval[c], "R6 invalidations", int'(inval_c[c*CW +: CW]), e_inval[c]);
    end
  endtask

  task automatic cycle();
    int g;
    logic [NC-1:0] exp_g;
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      valid[c] = s_pos[c] < s_len[c];
      store[c] = valid[c] ? s_st[c][s_pos[c]] : 1'b0;
      addr[c*AW +: AW] = valid[c] ? AW'(s_addr[c][s_pos[c]]) : '0;
    end
    #1;
    g = pick(valid);
    exp_g = '0;
    if (g >= 0) exp_g[g] = 1'b1;
    chk(grant == exp_g, "R2 grant", int'(grant), int'(exp_g));
    @(posedge clk);
    if (g >= 0) begin
      model_access(g, s_st[g][s_pos[g]], s_addr[g][s_pos[g]]);
      s_pos[g]++;
      rr_last = g;
    end
    #1;
    cmp_all();
  endtask

  task automatic dir_acc(int c, bit st, int a);
    for (int k = 0; k < NC; k++) s_len[k] = s_pos[k];
    s_addr[c][s_pos[c]] = a;
    s_st[c][s_pos[c]] = st;
    s_len[c] = s_pos[c] + 1;
    cycle();
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    valid = '0; store = '0; addr = '0;
    model_reset();
    for (int c = 0; c < NC; c++) begin s_len[c] = 0; s_pos[c] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1: counters clear after reset
    cmp_all();
    chk(int'(miss_c[0 +: CW]) == 0, "R1 reset miss", int'(miss_c[0 +: CW]), 0);

    // set 0, tags 1,2,3 on core 0 (R1, R3, R4, R5)
    dir_acc(0, 1'b0, 8'h04);
    chk(int'(miss_c[0 +: CW]) == 1, "R1 first access misses", int'(miss_c[0 +: CW]), 1);
    dir_acc(0, 1'b0, 8'h08);
    dir_acc(0, 1'b0, 8'h04);
    chk(int'(hit_c[0 +: CW]) == 1, "R3 reload hit", int'(hit_c[0 +: CW]), 1);
    dir_acc(0, 1'b0, 8'h0C);
    chk(int'(evict_c[0 +: CW]) == 1, "R4 full set evicts", int'(evict_c[0 +: CW]), 1);
    dir_acc(0, 1'b0, 8'h04);
    chk(int'(hit_c[0 +: CW]) == 2, "R5 LRU victim spared recent line", int'(hit_c[0 +: CW]), 2);

    // coherence chain on set 1 (R6, R7, R8, R9)
    dir_acc(0, 1'b1, 8'h01);
    dir_acc(1, 1'b0, 8'h01);
    dir_acc(0, 1'b1, 8'h01);
    chk(int'(inval_c[1*CW +: CW]) == 1, "R7 downgraded owner store invalidates reader", int'(inval_c[1*CW +: CW]), 1);
    dir_acc(1, 1'b0, 8'h01);
    chk(int'(miss_c[1*CW +: CW]) == 2, "R9 invalidated line misses", int'(miss_c[1*CW +: CW]), 2);
    chk(int'(evict_c[1*CW +: CW]) == 0, "R9 refill without eviction", int'(evict_c[1*CW +: CW]), 0);
    dir_acc(2, 1'b1, 8'h01);
    chk(int'(inval_c[0 +: CW]) == 1, "R6 store miss invalidates cache 0", int'(inval_c[0 +: CW]), 1);
    chk(int'(inval_c[1*CW +: CW]) == 2, "R6 store miss invalidates cache 1", int'(inval_c[1*CW +: CW]), 2);
    dir_acc(2, 1'b1, 8'h01);
    chk(int'(hit_c[2*CW +: CW]) == 1, "R8 store hit on Modified", int'(hit_c[2*CW +: CW]), 1);
    chk(int'(inval_c[0 +: CW]) == 1, "R8 no effect on other caches", int'(inval_c[0 +: CW]), 1);

    // R2: all cores at once, then random streams of unequal length
    for (int c = 0; c < NC; c++) begin
      s_pos[c] = 0;
      s_len[c] = (c == 3) ? 0 : 20 + 25 * c + int'($urandom_range(0, 10));
      for (int k = 0; k < s_len[c]; k++) begin
        s_addr[c][k] = int'($urandom_range(0, 15));
        s_st[c][k] = ($urandom_range(0, 2) == 0);
      end
    end
    while (s_pos[0] < s_len[0] || s_pos[1] < s_len[1] || s_pos[2] < s_len[2] || s_pos[3] < s_len[3])
      cycle();
    for (int c = 0; c < NC; c++) begin
      s_pos[c] = 0;
      s_len[c] = 30 + int'($urandom_range(0, 60));
      for (int k = 0; k < s_len[c]; k++) begin
        s_addr[c][k] = int'($urandom_range(0, 23));
        s_st[c][k] = ($urandom_range(0, 1) == 0);
      end
    end
    while (s_pos[0] < s_len[0] || s_pos[1] < s_len[1] || s_pos[2] < s_len[2] || s_pos[3] < s_len[3])
      cycle();
    cycle();

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule